// File: doc/BRIEF.md
# Sequential Multi-Width Shifter with Condition Flags

This block is an iterative shift engine for byte (8-bit), word (16-bit) and long (32-bit) operands. It performs a logical left shift, a logical right shift or an arithmetic right shift. It moves the operand by one bit position per clock cycle. Its timing follows an instruction-style cost: a fixed preparation time, set by a parameter, followed by one cycle for every bit position shifted. Along with the shifted value it returns five condition flags:

- zero
- negative
- carry (the last bit pushed out)
- overflow (on a left shift, the sign bit changed)
- sticky (on a right shift, a 1 held in carry was pushed out again)

The shift amount has two sources, picked per operation. One is a 4-bit immediate (0 to 15). The other is a full 8-bit register value (0 to 255). Amounts at or past the operand width are not clamped. The shift simply continues until the value holds only zeros, or only copies of the sign for the arithmetic case.

Operations arrive on a valid/ready request channel and leave on a valid/ready result channel. Only one operation is in flight at a time. `in_ready` is high only while the engine is idle. Once a request is taken, `in_ready` stays low until the result has been handed over. A result is presented with `res_valid` and is held unchanged, data and flags alike, for as long as `res_ready` stays low. The result handshake returns the engine to idle on the next edge. The fields on the request side matter only in the cycle of the request handshake.

Top module: `shf_seq_shifter`

## Requirements
- R1: `in_ready` is high exactly when the engine is idle: after reset, and from the edge after a result handshake until the next request handshake. `in_ready` and `res_valid` are never high together.
- R2: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_data` and all flags stay unchanged. After a result handshake, `res_valid` is low on the next cycle.
- R3: `res_valid` first rises exactly `OVERHEAD + count` clock edges after the edge that accepts the request, where count is the selected shift amount.
- R4: `in_cnt_sel` = 0 takes the shift amount from the 4-bit `in_imm_cnt` (0..15). `in_cnt_sel` = 1 takes it from the 8-bit `in_reg_cnt` (0..255).
- R5: `in_width` selects the operand size: 2'b00 = 8 bits, 2'b01 = 16 bits, 2'b10 and 2'b11 = 32 bits. Input bits above the selected size are ignored, and result bits above it are 0.
- R6: `in_op` = 2'b00 is a logical left shift. Zeros enter at bit 0, carry holds the last bit shifted out of the top, overflow is set if the top bit changed on any step, and sticky is 0.
- R7: `in_op` = 2'b01 and 2'b11 are a logical right shift. Zeros enter at the top, carry holds the last bit shifted out of bit 0, and overflow is 0.
- R8: `in_op` = 2'b10 is an arithmetic right shift. Each step copies the top bit into the vacated top position and sets carry to the bit leaving bit 0. Overflow is 0.
- R9: Sticky starts at 0 for every operation. On a right shift it becomes 1 when a step pushes out a carry that already holds 1.
- R10: Zero is 1 exactly when the result at the selected size is 0. Negative equals the result's top bit at the selected size.
- R11: A shift amount of 0 returns the masked operand unchanged, with carry, overflow and sticky at 0, after `OVERHEAD` cycles.
- R12: Amounts of the operand size or more keep shifting one bit per cycle. The result becomes all zeros for logical shifts and all copies of the sign for arithmetic shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Engine idle, request can be taken |
| in_data | input | DATA_W | Operand |
| in_width | input | 2 | Operand size select |
| in_op | input | 2 | Shift kind select |
| in_cnt_sel | input | 1 | Shift amount source: 0 immediate, 1 register |
| in_imm_cnt | input | IMM_W | Immediate shift amount |
| in_reg_cnt | input | CNT_W | Register shift amount |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | DATA_W | Shifted value, zero above the selected size |
| res_z | output | 1 | Result is zero |
| res_n | output | 1 | Top bit of the result |
| res_c | output | 1 | Last bit shifted out |
| res_v | output | 1 | Sign bit changed during a left shift |
| res_st | output | 1 | Sticky bit of a right shift |

## Verification
The checker treats the request fields as meaningful only in the handshake cycle. It records the amount, kind, size and masked operand at that edge and judges the result against those records. This assumes reset is applied before the first request and that `OVERHEAD` is at least 1. The bench drives every input on the falling edge and holds each field steady across the accepting edge. It drops `in_valid` right after the handshake, so no request is ever offered while the engine is busy. The sweep covers every size code, including the reserved one, and every kind code. It uses all 16 immediate amounts and a set of register amounts around and far beyond each size, on operands with junk in the upper bits. It withholds `res_ready` for a varying number of cycles to exercise the hold rule.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [1:0] {
    W_BYTE = 2'b00,
    W_WORD = 2'b01,
    W_LONG = 2'b10,
    W_RSVD = 2'b11
  } width_e;

  typedef enum logic [1:0] {
    OP_SHL  = 2'b00,
    OP_SHR  = 2'b01,
    OP_SAR  = 2'b10,
    OP_RSVD = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PREP,
    ST_SHIFT,
    ST_DONE
  } state_e;

  typedef struct packed {
    logic c;
    logic v;
    logic st;
  } cflags_t;

  // lane index for a size code: 0 quarter, 1 half, 2 full width
  function automatic logic [1:0] lane_of(width_e w);
    case (w)
      W_BYTE:  return 2'd0;
      W_WORD:  return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/shf_count_sel.sv
module shf_count_sel #(
  parameter int IMM_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             sel,
  input  logic [IMM_W-1:0] imm_cnt,
  input  logic [CNT_W-1:0] reg_cnt,
  output logic [CNT_W-1:0] cnt
);
  localparam int PAD_W = CNT_W - IMM_W;

  assign cnt = sel ? reg_cnt : {{PAD_W{1'b0}}, imm_cnt};
endmodule

// File: rtl/shf_step.sv
module shf_step
  import shf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] d_in,
  input  width_e            w,
  input  op_e               op,
  input  cflags_t           f_in,
  output logic [DATA_W-1:0] d_out,
  output cflags_t           f_out
);
  localparam int NLANE = 3;

  logic [DATA_W-1:0] lane_d    [NLANE];
  logic [NLANE-1:0]  lane_c;
  logic [NLANE-1:0]  lane_flip;
  logic [1:0]        lsel;
  logic              is_left;

  assign is_left = (op == OP_SHL);
  assign lsel    = lane_of(w);

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LW = DATA_W >> (NLANE - 1 - g);
    logic [LW-1:0] src;
    logic [LW-1:0] res;
    logic          fill;
    logic          lc;

    assign src  = d_in[LW-1:0];
    assign fill = (op == OP_SAR) && src[LW-1];

    always_comb begin
      if (is_left) begin
        res = {src[LW-2:0], 1'b0};
        lc  = src[LW-1];
      end else begin
        res = {fill, src[LW-1:1]};
        lc  = src[0];
      end
    end

    assign lane_d[g]    = DATA_W'(res);
    assign lane_c[g]    = lc;
    assign lane_flip[g] = is_left && (res[LW-1] != src[LW-1]);
  end

  always_comb begin
    d_out   = lane_d[lsel];
    f_out.c = lane_c[lsel];
    f_out.v = f_in.v | lane_flip[lsel];
    // a right step that pushes out a carry already at 1 sets sticky
    f_out.st = is_left ? f_in.st : (f_in.st | f_in.c);
  end
endmodule

// File: rtl/shf_flag_eval.sv
module shf_flag_eval
  import shf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] data,
  input  width_e            w,
  output logic              z,
  output logic              n
);
  localparam int NLANE = 3;

  logic [NLANE-1:0] lz;
  logic [NLANE-1:0] ln;
  logic [1:0]       lsel;

  assign lsel = lane_of(w);

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LW = DATA_W >> (NLANE - 1 - g);
    assign lz[g] = (data[LW-1:0] == '0);
    assign ln[g] = data[LW-1];
  end

  assign z = lz[lsel];
  assign n = ln[lsel];
endmodule

// File: rtl/shf_ctrl.sv
module shf_ctrl
  import shf_pkg::*;
#(
  parameter int OVERHEAD = 7,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [CNT_W-1:0] cnt,
  input  logic             res_ready,
  output logic             in_ready,
  output logic             res_valid,
  output logic             load,
  output logic             step_en
);
  localparam int TMR_W = (OVERHEAD > 1) ? $clog2(OVERHEAD) : 1;

  state_e           st_q;
  logic [TMR_W-1:0] tmr_q;
  logic [CNT_W-1:0] rem_q;

  assign in_ready  = (st_q == ST_IDLE);
  assign res_valid = (st_q == ST_DONE);
  assign load      = in_ready && in_valid;
  assign step_en   = (st_q == ST_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
      rem_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (in_valid) begin
            st_q  <= ST_PREP;
            tmr_q <= TMR_W'(OVERHEAD - 1);
            rem_q <= cnt;
          end
        end
        ST_PREP: begin
          if (tmr_q == '0) begin
            st_q <= (rem_q == '0) ? ST_DONE : ST_SHIFT;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        ST_SHIFT: begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) st_q <= ST_DONE;
        end
        default: begin
          if (res_ready) st_q <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/shf_seq_shifter.sv
module shf_seq_shifter
  import shf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IMM_W    = 4,
  parameter int CNT_W    = 8,
  parameter int OVERHEAD = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        in_width,
  input  logic [1:0]        in_op,
  input  logic              in_cnt_sel,
  input  logic [IMM_W-1:0]  in_imm_cnt,
  input  logic [CNT_W-1:0]  in_reg_cnt,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  output logic              res_z,
  output logic              res_n,
  output logic              res_c,
  output logic              res_v,
  output logic              res_st
);
  localparam int QW = DATA_W / 4;
  localparam int HW = DATA_W / 2;

  logic [CNT_W-1:0]  cnt;
  logic              load;
  logic              step_en;
  logic [DATA_W-1:0] in_masked;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] data_nx;
  width_e            w_q;
  op_e               op_q;
  cflags_t           fl_q;
  cflags_t           fl_nx;

  shf_count_sel #(.IMM_W(IMM_W), .CNT_W(CNT_W)) u_cnt (
    .sel     (in_cnt_sel),
    .imm_cnt (in_imm_cnt),
    .reg_cnt (in_reg_cnt),
    .cnt     (cnt)
  );

  shf_ctrl #(.OVERHEAD(OVERHEAD), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .cnt       (cnt),
    .res_ready (res_ready),
    .in_ready  (in_ready),
    .res_valid (res_valid),
    .load      (load),
    .step_en   (step_en)
  );

  always_comb begin
    case (width_e'(in_width))
      W_BYTE:  in_masked = {{(DATA_W-QW){1'b0}}, in_data[QW-1:0]};
      W_WORD:  in_masked = {{(DATA_W-HW){1'b0}}, in_data[HW-1:0]};
      default: in_masked = in_data;
    endcase
  end

  shf_step #(.DATA_W(DATA_W)) u_step (
    .d_in  (data_q),
    .w     (w_q),
    .op    (op_q),
    .f_in  (fl_q),
    .d_out (data_nx),
    .f_out (fl_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      w_q    <= W_BYTE;
      op_q   <= OP_SHL;
      fl_q   <= '0;
    end else if (load) begin
      data_q <= in_masked;
      w_q    <= width_e'(in_width);
      op_q   <= op_e'(in_op);
      fl_q   <= '0;
    end else if (step_en) begin
      data_q <= data_nx;
      fl_q   <= fl_nx;
    end
  end

  shf_flag_eval #(.DATA_W(DATA_W)) u_flags (
    .data (data_q),
    .w    (w_q),
    .z    (res_z),
    .n    (res_n)
  );

  assign res_data = data_q;
  assign res_c    = fl_q.c;
  assign res_v    = fl_q.v;
  assign res_st   = fl_q.st;
endmodule

// File: rtl/shf_seq_shifter_chk.sv
module shf_seq_shifter_chk #(
  parameter int DATA_W   = 32,
  parameter int IMM_W    = 4,
  parameter int CNT_W    = 8,
  parameter int OVERHEAD = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic [1:0]        in_width,
  input logic [1:0]        in_op,
  input logic              in_cnt_sel,
  input logic [IMM_W-1:0]  in_imm_cnt,
  input logic [CNT_W-1:0]  in_reg_cnt,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_data,
  input logic              res_z,
  input logic              res_c,
  input logic              res_v,
  input logic              res_st
);
  localparam int QW = DATA_W / 4;
  localparam int HW = DATA_W / 2;

  logic [CNT_W-1:0]  cap_cnt;
  logic [1:0]        cap_op;
  logic [1:0]        cap_w;
  logic [DATA_W-1:0] cap_data;
  logic [31:0]       lat;
  logic              acc;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_cnt  <= '0;
      cap_op   <= '0;
      cap_w    <= '0;
      cap_data <= '0;
      lat      <= '0;
    end else if (acc) begin
      cap_cnt  <= in_cnt_sel ? in_reg_cnt : CNT_W'(in_imm_cnt);
      cap_op   <= in_op;
      cap_w    <= in_width;
      case (in_width)
        2'b00:   cap_data <= {{(DATA_W-QW){1'b0}}, in_data[QW-1:0]};
        2'b01:   cap_data <= {{(DATA_W-HW){1'b0}}, in_data[HW-1:0]};
        default: cap_data <= in_data;
      endcase
      lat <= '0;
    end else if (!in_ready && !res_valid) begin
      lat <= lat + 1;
    end
  end

  assert_ready_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && res_valid));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) &&
      $stable({res_z, res_c, res_v, res_st}));

  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> !res_valid);

  // R4: captured amount already reflects the selected source
  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> lat == 32'(OVERHEAD) + 32'(cap_cnt));

  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && cap_w == 2'b00 |-> res_data[DATA_W-1:QW] == '0);

  assert_left_no_st_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && cap_op == 2'b00 |-> !res_st);

  assert_right_no_v_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && cap_op != 2'b00 |-> !res_v);

  assert_zero_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_z == (res_data == '0));

  assert_zero_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && cap_cnt == '0 |-> res_data == cap_data && !res_c && !res_v && !res_st);

endmodule

bind shf_seq_shifter shf_seq_shifter_chk #(
  .DATA_W(DATA_W), .IMM_W(IMM_W), .CNT_W(CNT_W), .OVERHEAD(OVERHEAD)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_data    (in_data),
  .in_width   (in_width),
  .in_op      (in_op),
  .in_cnt_sel (in_cnt_sel),
  .in_imm_cnt (in_imm_cnt),
  .in_reg_cnt (in_reg_cnt),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_data   (res_data),
  .res_z      (res_z),
  .res_c      (res_c),
  .res_v      (res_v),
  .res_st     (res_st)
);

// File: tb/tb_shf_seq_shifter.sv
`timescale 1ns/1ps
module tb_shf_seq_shifter;
  localparam int OVH = 7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic [1:0]  in_width;
  logic [1:0]  in_op;
  logic        in_cnt_sel;
  logic [3:0]  in_imm_cnt;
  logic [7:0]  in_reg_cnt;
  logic        res_valid;
  logic        res_ready;
  logic [31:0] res_data;
  logic        res_z, res_n, res_c, res_v, res_st;

  int checks = 0;
  int errors = 0;
  logic [31:0] last_data;
  logic        last_c, last_st;

  always #4 clk = ~clk;

  shf_seq_shifter #(.DATA_W(32), .IMM_W(4), .CNT_W(8), .OVERHEAD(OVH)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_width(in_width), .in_op(in_op),
    .in_cnt_sel(in_cnt_sel), .in_imm_cnt(in_imm_cnt), .in_reg_cnt(in_reg_cnt),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_z(res_z), .res_n(res_n), .res_c(res_c), .res_v(res_v), .res_st(res_st)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_op(input int w, input int op, input bit sel, input int imm,
                       input int regc, input logic [31:0] opnd, input int hold);
    int wb, cnt, k;
    logic [31:0] mask, d, hd;
    logic c, v, st, msb;
    string dtag;
    wb   = (w == 0) ? 8 : (w == 1) ? 16 : 32;
    mask = (wb == 32) ? 32'hFFFF_FFFF : ((32'd1 << wb) - 32'd1);
    cnt  = sel ? regc : imm;
    d = opnd & mask; c = 1'b0; v = 1'b0; st = 1'b0;
    for (int i = 0; i < cnt; i++) begin
      msb = d[wb-1];
      if (op == 0) begin
        c = msb;
        d = (d << 1) & mask;
        if (d[wb-1] != msb) v = 1'b1;
      end else begin
        st = st | c;
        c  = d[0];
        d  = (d >> 1) | (((op == 2) && msb) ? (32'd1 << (wb - 1)) : 32'd0);
      end
    end
    if (cnt == 0)       dtag = "R11";
    else if (cnt >= wb) dtag = "R12";
    else if (op == 0)   dtag = "R6";
    else if (op == 2)   dtag = "R8";
    else                dtag = "R7";

    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = opnd; in_width = 2'(w); in_op = 2'(op);
    in_cnt_sel = sel; in_imm_cnt = 4'(imm); in_reg_cnt = 8'(regc);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", "in_ready while busy", {31'd0, in_ready}, 32'd0);
    k = 1;
    while (!res_valid && k < 2000) begin
      @(negedge clk);
      k++;
    end
    chk(sel ? "R4" : "R3", "latency", 32'(k - 1), 32'(OVH + cnt));
    chk(dtag, "data", res_data, d);
    chk((op == 0) ? "R6" : (op == 2) ? "R8" : "R7", "carry", {31'd0, res_c}, {31'd0, c});
    chk((op == 0) ? "R6" : "R7", "overflow", {31'd0, res_v}, {31'd0, v});
    chk("R9", "sticky", {31'd0, res_st}, {31'd0, st});
    chk("R10", "zero/neg", {30'd0, res_z, res_n}, {30'd0, (d == 32'd0), d[wb-1]});
    if (wb < 32) chk("R5", "upper bits", res_data & ~mask, 32'd0);
    last_data = res_data; last_c = res_c; last_st = res_st;
    hd = res_data;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R2", "held valid+data", {res_valid, res_data[30:0]}, {1'b1, hd[30:0]});
    end
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    res_ready = 1'b0;
    chk("R2", "valid after handshake", {31'd0, res_valid}, 32'd0);
    chk("R1", "ready after handshake", {31'd0, in_ready}, 32'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog: got no completion expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] ops [3];
    int regs [6];
    ops[0] = 32'hA5C3_533D; ops[1] = 32'h7F00_ABCD; ops[2] = 32'h8001_F0F0;
    regs[0] = 0; regs[1] = 16; regs[2] = 31; regs[3] = 32; regs[4] = 33; regs[5] = 200;
    rst_n = 1'b0; in_valid = 1'b0; res_ready = 1'b0; in_data = '0; in_width = '0;
    in_op = '0; in_cnt_sel = 1'b0; in_imm_cnt = '0; in_reg_cnt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset in_ready", {31'd0, in_ready}, 32'd1);
    chk("R1", "reset res_valid", {31'd0, res_valid}, 32'd0);

    // worked values
    do_op(1, 0, 1'b0, 2, 0, 32'h0000_533D, 2);
    chk("R6", "word left 2", last_data, 32'h0000_4CF4);
    chk("R6", "word left 2 carry", {31'd0, last_c}, 32'd1);
    do_op(1, 1, 1'b0, 4, 0, 32'h0000_ABCD, 0);
    chk("R7", "word right 4", last_data, 32'h0000_0ABC);
    chk("R9", "word right 4 sticky", {31'd0, last_st}, 32'd1);
    do_op(0, 2, 1'b0, 3, 0, 32'h0000_00F0, 1);
    chk("R8", "byte arith 3", last_data, 32'h0000_00FE);
    do_op(1, 2, 1'b1, 0, 20, 32'h0000_8000, 0);
    chk("R12", "word arith 20", last_data, 32'h0000_FFFF);

    for (int w = 0; w < 4; w++)
      for (int op = 0; op < 4; op++)
        for (int n = 0; n < 16; n++)
          for (int o = 0; o < 3; o++)
            do_op(w, op, 1'b0, n, 0, ops[o], n % 3);

    for (int w = 0; w < 4; w++)
      for (int op = 0; op < 4; op++)
        for (int r = 0; r < 6; r++)
          for (int o = 1; o < 3; o++)
            do_op(w, op, 1'b1, 5, regs[r], ops[o], 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule